// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable single-port synchronous SRAM with a 32-bit data word and byte-lane writes. It can take a read, a write or a deselect on every enabled clock edge with no idle cycles between them. A read returns its word one enabled edge after the command. A write takes its data from the bus two enabled edges after the address. Because of this late write, the data bus carries a word in every cycle whatever the mix of reads and writes.

The shared bidirectional bus is split into three ports: `dqIn`, `dqOut` and `dqOe`. Three chip selects, a load strobe and an active-low clock enable qualify each command. The output drive is gated in two ways: by an asynchronous active-low output enable, and by an internal flag that is set only for a read data cycle.

Burst address generation belongs to a separate block. When `loadN` is high on an enabled edge, this block starts no access. Memory depth is `2**ADDR_W` words.

Top module: `nowait_sram`

## Requirements
- R1: A new access starts at a rising edge only if `clkEnN`=0, `selAN`=0, `selB`=1, `selCN`=0 and `loadN`=0. Any other enabled edge is a deselect: nothing is written and no data is driven for it.
- R2: A read (`writeN`=1) puts the word at its address on `dqOut` after the next enabled edge, with `dqOe`=1 when `driveEnN`=0.
- R3: For a write (`writeN`=0), `dqOe` is 0 after the next enabled edge, whatever `driveEnN` is. `dqIn` is sampled at the second enabled edge after the command and stored.
- R4: Byte select `laneN[k]` is active low and is sampled with the command. It enables writing bits 8k+7..8k. Lanes whose select is 1 keep their old contents.
- R5: Commands of any mix (read, write, deselect) are accepted on consecutive enabled edges, and every read returns the result of all earlier writes.
- R6: A read issued on the enabled edge right after a write to the same address returns the new data, merged by that write's byte selects.
- R7: While `clkEnN`=1, no state changes: `dqOut`, `dqOe`, pending commands and memory contents all hold.
- R8: After a deselecting edge, the outputs turn off after the following enabled edge and stay off while the device remains deselected.
- R9: `driveEnN`=1 forces `dqOe` to 0 at once, without waiting for a clock edge.
- R10: Reset (`rstN`=0) empties the pipeline, giving `dqOe`=0 and `dqOut`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Word address |
| selAN | input | 1 | Chip select A, active low |
| selB | input | 1 | Chip select B, active high |
| selCN | input | 1 | Chip select C, active low |
| writeN | input | 1 | Write command, active low |
| laneN | input | 4 | Byte-lane write selects, active low |
| clkEnN | input | 1 | Clock enable, active low |
| loadN | input | 1 | Load strobe, low starts an access |
| driveEnN | input | 1 | Asynchronous output enable, active low |
| dqIn | input | 32 | Data bus input side |
| dqOut | output | 32 | Data bus output side |
| dqOe | output | 1 | Data bus drive enable |

## Verification
The assertions check the following on every cycle:
- a stalled edge changes no pipeline flag and no output word;
- a non-qualifying edge starts no access;
- a write command or an empty stage never raises the drive flag;
- the drive flag rises only after a read;
- the output enable masks the drive.

Only the bench's scenarios can show that the data is right. This covers byte-merged writes, same-address forwarding in the cycle after a write, and values that survive stalls and deselects. Those scenarios compare every driven word against a bench memory model under random command mixes.

// File: rtl/nowait_sram_pkg.sv
package nowait_sram_pkg;
  localparam int LANE_W = 8;
  localparam int LANES  = 4;
  localparam int DATA_W = LANE_W * LANES;

  // Strobes from control to datapath
  typedef struct packed {
    logic             step;     // enabled clock edge
    logic             doWrite;  // late-write stage stores this edge
    logic             loadOut;  // output register captures read data
    logic [LANES-1:0] wrLanes;  // active-high lanes of pending write
    logic [LANES-1:0] fwdLanes; // lanes bypassed from dqIn into output
  } strobe_t;
endpackage

// File: rtl/nowait_sram_ctrl.sv
module nowait_sram_ctrl
  import nowait_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              selAN,
  input  logic              selB,
  input  logic              selCN,
  input  logic              writeN,
  input  logic [LANES-1:0]  laneN,
  input  logic              clkEnN,
  input  logic              loadN,
  output strobe_t           strb,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] wrAddr,
  output logic              driveFlag
);
  logic              startCmd;
  logic              st1Valid, st1Write;
  logic [ADDR_W-1:0] st1Addr;
  logic [LANES-1:0]  st1Lanes;
  logic              wrValid;
  logic [ADDR_W-1:0] wrAddrQ;
  logic [LANES-1:0]  wrLanesQ;
  logic              driveQ;
  logic              sameAddr;

  assign startCmd = !selAN && selB && !selCN && !loadN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st1Valid <= 1'b0;
      st1Write <= 1'b0;
      st1Addr  <= '0;
      st1Lanes <= '0;
      wrValid  <= 1'b0;
      wrAddrQ  <= '0;
      wrLanesQ <= '0;
      driveQ   <= 1'b0;
    end else if (!clkEnN) begin
      st1Valid <= startCmd;
      st1Write <= !writeN;
      st1Addr  <= addr;
      st1Lanes <= ~laneN;
      wrValid  <= st1Valid && st1Write;
      wrAddrQ  <= st1Addr;
      wrLanesQ <= st1Lanes;
      driveQ   <= st1Valid && !st1Write;
    end
  end

  assign sameAddr = wrValid && (wrAddrQ == st1Addr);

  always_comb begin
    strb.step     = !clkEnN;
    strb.doWrite  = wrValid;
    strb.loadOut  = st1Valid && !st1Write;
    strb.wrLanes  = wrLanesQ;
    strb.fwdLanes = sameAddr ? wrLanesQ : '0;
  end

  assign rdAddr    = st1Addr;
  assign wrAddr    = wrAddrQ;
  assign driveFlag = driveQ;

  assert_no_start_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && (selAN || !selB || selCN || loadN)) |=> !st1Valid);

  assert_drive_after_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(driveQ) |-> $past(st1Valid && !st1Write));

  assert_write_releases_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && st1Valid && st1Write) |=> !driveQ);

  assert_stall_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    clkEnN |=> ($stable(st1Valid) && $stable(wrValid) && $stable(driveQ)));

  assert_deselect_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && !st1Valid) |=> !driveQ);
endmodule

// File: rtl/nowait_sram_dpath.sv
module nowait_sram_dpath
  import nowait_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] dqOut
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    logic [LANE_W-1:0] laneQ;
    logic [LANE_W-1:0] busLane;

    assign busLane = dqIn[k*LANE_W +: LANE_W];

    always_ff @(posedge clk) begin
      if (strb.step && strb.doWrite && strb.wrLanes[k])
        cells[wrAddr] <= busLane;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        laneQ <= '0;
      else if (strb.step && strb.loadOut)
        laneQ <= strb.fwdLanes[k] ? busLane : cells[rdAddr];
    end

    assign dqOut[k*LANE_W +: LANE_W] = laneQ;
  end

  assert_out_stall_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.step |=> $stable(dqOut));

  assert_fwd_needs_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fwdLanes != '0) |-> strb.doWrite);
endmodule

// File: rtl/nowait_sram.sv
module nowait_sram
  import nowait_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              selAN,
  input  logic              selB,
  input  logic              selCN,
  input  logic              writeN,
  input  logic [3:0]        laneN,
  input  logic              clkEnN,
  input  logic              loadN,
  input  logic              driveEnN,
  input  logic [31:0]       dqIn,
  output logic [31:0]       dqOut,
  output logic              dqOe
);
  strobe_t           strb;
  logic [ADDR_W-1:0] rdAddr, wrAddr;
  logic              driveFlag;

  nowait_sram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .selAN(selAN), .selB(selB),
    .selCN(selCN), .writeN(writeN), .laneN(laneN), .clkEnN(clkEnN),
    .loadN(loadN), .strb(strb), .rdAddr(rdAddr), .wrAddr(wrAddr),
    .driveFlag(driveFlag)
  );

  nowait_sram_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .rdAddr(rdAddr), .wrAddr(wrAddr),
    .dqIn(dqIn), .dqOut(dqOut)
  );

  assign dqOe = driveFlag && !driveEnN;

  assert_oe_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    driveEnN |-> !dqOe);
endmodule

// File: tb/nowait_sram_tb.sv
module nowait_sram_tb;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rstN;
  logic [AW-1:0] addr;
  logic          selAN, selB, selCN, writeN, clkEnN, loadN, driveEnN;
  logic [3:0]    laneN;
  logic [31:0]   dqIn, dqOut;
  logic          dqOe;

  nowait_sram #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .selAN(selAN), .selB(selB),
    .selCN(selCN), .writeN(writeN), .laneN(laneN), .clkEnN(clkEnN),
    .loadN(loadN), .driveEnN(driveEnN), .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] model [DEPTH];
  bit          s1Valid = 0, s1Write = 0, s2Write = 0;
  logic [31:0] s1Data = '0, s2Data = '0;
  bit          expDrive = 0;
  logic [31:0] expOut = '0;

  function automatic logic [31:0] mergeLanes(logic [31:0] old, logic [31:0] nw, logic [3:0] ln);
    logic [31:0] r = old;
    for (int k = 0; k < 4; k++)
      if (!ln[k]) r[k*8 +: 8] = nw[k*8 +: 8];
    return r;
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // kind: 0 read, 1 write, 2 deselect, 3 write attempt with a bad qualifier
  task automatic cycle(int kind, logic [AW-1:0] a, logic [3:0] ln, logic [31:0] d,
                       bit stall, bit oeN, string tag);
    @(negedge clk);
    addr = a; laneN = ln; writeN = !(kind == 1 || kind == 3);
    selAN = 0; selB = 1; selCN = 0; loadN = 0;
    if (kind >= 2) begin
      case (d[1:0])
        2'd0: selAN = 1;
        2'd1: selB = 0;
        2'd2: selCN = 1;
        default: loadN = 1;
      endcase
    end
    clkEnN = stall; driveEnN = oeN;
    dqIn = s2Write ? s2Data : $urandom;
    if (!stall) begin
      expDrive = s1Valid && !s1Write;
      if (expDrive) expOut = s1Data;
      s2Write = s1Valid && s1Write;
      s2Data = s1Data;
      s1Valid = (kind <= 1);
      s1Write = (kind == 1);
      if (kind == 1) begin
        s1Data = d;
        model[a] = mergeLanes(model[a], d, ln);
      end else if (kind == 0) begin
        s1Data = model[a];
      end
    end
    @(posedge clk);
    #5;
    check(tag, "dqOe", {31'b0, dqOe}, {31'b0, expDrive && !oeN});
    if (expDrive && !oeN) check(tag, "dqOut", dqOut, expOut);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R5 watchdog actual=timeout expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rstN = 0; addr = '0; selAN = 1; selB = 0; selCN = 1; writeN = 1;
    laneN = 4'hF; clkEnN = 0; loadN = 1; driveEnN = 0; dqIn = '0;
    repeat (3) @(posedge clk);
    #5;
    check("R10", "dqOe reset", {31'b0, dqOe}, 32'd0);
    check("R10", "dqOut reset", dqOut, 32'd0);
    @(negedge clk); rstN = 1;

    // R5: back-to-back writes fill the whole array
    for (int i = 0; i < DEPTH; i++) cycle(1, AW'(i), 4'h0, $urandom, 0, 0, "R5");
    cycle(2, 0, 4'hF, 32'd0, 0, 0, "R8");
    cycle(2, 0, 4'hF, 32'd1, 0, 0, "R8");

    // R2: plain reads
    for (int i = 0; i < 6; i++) cycle(0, AW'(i * 7), 4'hF, 0, 0, 0, "R2");
    // R8: deselect then outputs off
    cycle(2, 0, 4'hF, 32'd2, 0, 0, "R8");
    cycle(2, 0, 4'hF, 32'd3, 0, 0, "R8");
    cycle(2, 0, 4'hF, 32'd0, 0, 0, "R8");

    // R1: writes with one bad qualifier each, then read back unchanged
    for (int i = 0; i < 4; i++) cycle(3, 8'h10, 4'h0, 32'(i), 0, 0, "R1");
    cycle(0, 8'h10, 4'hF, 0, 0, 0, "R1");
    cycle(2, 0, 4'hF, 0, 0, 0, "R1");
    cycle(2, 0, 4'hF, 0, 0, 0, "R1");

    // R4: partial lane writes
    cycle(1, 8'h20, 4'b1010, 32'hA1B2C3D4, 0, 0, "R4");
    cycle(1, 8'h21, 4'b0111, 32'h11223344, 0, 0, "R4");
    cycle(2, 0, 4'hF, 0, 0, 0, "R4");
    cycle(0, 8'h20, 4'hF, 0, 0, 0, "R4");
    cycle(0, 8'h21, 4'hF, 0, 0, 0, "R4");
    cycle(2, 0, 4'hF, 0, 0, 0, "R4");

    // R6: read immediately after write to same address, partial lanes
    cycle(1, 8'h30, 4'b0101, 32'hDEADBEEF, 0, 0, "R6");
    cycle(0, 8'h30, 4'hF, 0, 0, 0, "R6");
    cycle(1, 8'h30, 4'b1110, 32'h0BADF00D, 0, 0, "R6");
    cycle(0, 8'h30, 4'hF, 0, 0, 0, "R6");
    cycle(2, 0, 4'hF, 0, 0, 0, "R6");

    // R3: write data phase with output enable low keeps bus released
    cycle(1, 8'h40, 4'h0, 32'hCAFE0001, 0, 0, "R3");
    cycle(1, 8'h41, 4'h0, 32'hCAFE0002, 0, 0, "R3");
    cycle(0, 8'h40, 4'hF, 0, 0, 0, "R3");
    cycle(0, 8'h41, 4'hF, 0, 0, 0, "R3");

    // R7: stalls while a write is pending and while reading
    cycle(1, 8'h50, 4'h0, 32'h55667788, 0, 0, "R7");
    cycle(0, 8'h41, 4'hF, 0, 1, 0, "R7");
    cycle(0, 8'h41, 4'hF, 0, 0, 0, "R7");
    cycle(2, 0, 4'hF, 0, 1, 0, "R7");
    cycle(2, 0, 4'hF, 0, 1, 0, "R7");
    cycle(0, 8'h50, 4'hF, 0, 0, 0, "R7");
    cycle(2, 0, 4'hF, 0, 0, 0, "R7");

    // R9: asynchronous output enable while data is driven
    cycle(0, 8'h50, 4'hF, 0, 0, 0, "R9");
    cycle(2, 0, 4'hF, 0, 0, 0, "R9");
    driveEnN = 1; #1;
    check("R9", "dqOe async off", {31'b0, dqOe}, 32'd0);
    driveEnN = 0; #1;
    check("R9", "dqOe async on", {31'b0, dqOe}, 32'd1);
    cycle(2, 0, 4'hF, 0, 0, 0, "R9");

    // R5: random mix on a small address window
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 9);
      int kind = (r < 4) ? 0 : (r < 7) ? 1 : (r == 7) ? 2 : 3;
      cycle(kind, AW'($urandom_range(0, 7)), 4'($urandom), $urandom,
            ($urandom_range(0, 7) == 0), ($urandom_range(0, 9) == 0), "R5");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule